// File: doc/BRIEF.md
# Fault-Protected 12-bit Pulse-Width Generator

This block produces one pulse waveform from a 12-bit up-counter. A prescaler slows the count to one tick every 1, 2, 4 or 8 system clocks. The pin stays active while the count is below a duty compare value. In repeating mode the counter wraps at a period compare value. In one-shot mode it halts there. A polarity bit can invert the waveform at the pin. A write-only start bit clears the counter and prescaler and then starts counting.

An external fault line passes through a synchronizer and an edge detector. A valid edge forces the pin to its idle level, clears and stops the timer, and raises a sticky fault flag. The waveform can only start again after software clears the flag and issues a new start. The counter then begins at zero with the settings that were held before the fault.

Software reaches the block through a small write port with four addresses:

| Address | Register |
|---|---|
| 0 | control |
| 1 | period |
| 2 | duty |
| 3 | fault flag |

The control fields read back on a dedicated output.

Top module: `pwm12_fault_gen`

## Requirements
- R1: After reset `pwm_out` is 0, `fault_irq` is 0, `gpio_mode` is 1, `ctrl_rd` is 0 and the timer is stopped.
- R2: Control bits [5:4] select the count tick. Codes 0, 1, 2 and 3 advance the counter once every 1, 2, 4 and 8 clocks.
- R3: When control bit 6 is 0 (repeating mode), the generated level is active while the counter is below the duty value. A counter that equals the period value returns to 0 on its next tick, so one period lasts (period+1) ticks.
- R4: Control bit 3 is the polarity. At 0 the pin shows the generated level (active = 1). At 1 the pin shows the inverse, so the idle level becomes 1.
- R5: Writing control with bit 2 set clears the counter and prescaler and starts the timer, and it does so even while the timer is running. Writing bit 2 as 0 starts nothing, and `ctrl_rd[2]` always reads 0.
- R6: Control bits [1:0] set the port and fault mode:
  - 00: general-purpose pin, fault off.
  - 01: pulse pin, fault off.
  - 10: pulse pin, rising fault edge.
  - 11: pulse pin, falling fault edge.

  A valid edge on `fault_in` stops the timer, clears the counter and drives the pin idle. For a `fault_in` change that lands before clock edge k, this happens from edge k+2.
- R7: A fault sets `fault_irq`. The flag stays set until address 3 is written with bit 0 equal to 0. Writing 1 there has no effect.
- R8: A start is ignored while `fault_irq` is set. After the flag is cleared, a start resumes the waveform from count 0 with the settings held at the fault.
- R9: Writes to control bits [6:3] and [1:0] take effect only while the timer is stopped. While it runs, these writes are ignored.
- R10: With port mode 00, `gpio_mode` is 1 and the pin is held at the idle level.
- R11: When control bit 6 is 1 (one-shot mode), a tick with the counter equal to the period value stops the timer. The pin then stays idle until the next start.
- R12: Addresses 1 and 2 load the period and duty values at any time, and the next compare uses the new values. A duty above the period keeps the pin active for the whole period, and a duty of 0 keeps it idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 period, 2 duty, 3 fault flag |
| wr_data | input | 12 | Write data |
| fault_in | input | 1 | Asynchronous external fault line |
| pwm_out | output | 1 | Pulse pin |
| fault_irq | output | 1 | Sticky fault flag |
| gpio_mode | output | 1 | High when the pin is handed to general-purpose use |
| ctrl_rd | output | 12 | Control register readback; bit 2 is always 0 |

## Verification
A register write takes effect at the clock edge that accepts it, and the outputs are built directly from registers, so a start, a stop or a new compare value shows on the pin in the cycle after that edge. The counter moves once every 1, 2, 4 or 8 cycles after a start. A fault edge reaches the pin two edges after it is first sampled. A behavioural model in the bench steps once at every clock edge. It is compared with all outputs 2 ns after each rising edge, so every result is checked in the cycle it becomes due and never earlier or later.

// File: rtl/pwm12_pkg.sv
// Shared constants and types for the fault-protected pulse generator.
// Assumes a 2-bit register address space and control fields in the low 7 bits.
package pwm12_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] A_DUTY   = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAG   = 2'd3;

    // Control field positions
    localparam int B_PORT_LO = 0;
    localparam int B_START   = 2;
    localparam int B_POL     = 3;
    localparam int B_SEL_LO  = 4;
    localparam int B_MODE    = 6;

    typedef enum logic [1:0] {
        PM_GPIO      = 2'b00,
        PM_PULSE     = 2'b01,
        PM_FLT_RISE  = 2'b10,
        PM_FLT_FALL  = 2'b11
    } port_mode_e;

    typedef struct packed {
        logic       oneshot;
        logic [1:0] sel;
        logic       pol;
        port_mode_e pmode;
    } ctrl_t;

endpackage

// File: rtl/pwm12_prescaler.sv
// Count-tick prescaler: emits one tick every 2**sel clocks while enabled.
// Assumes clr has priority and that sel is held stable while enabled.
module pwm12_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] limit;

    // Terminal count for the selected division
    always_comb begin
        limit = PS_W'((32'd1 << sel) - 32'd1);
        tick  = en && (ps_q == limit);
    end

    // Prescaler state: clear, wrap on tick, or advance
    always_ff @(posedge clk) begin
        if (!rst_n)      ps_q <= '0;
        else if (clr)    ps_q <= '0;
        else if (en)     ps_q <= tick ? '0 : ps_q + 1'b1;
    end
endmodule

// File: rtl/pwm12_fault_det.sv
// Fault line synchronizer and edge detector.
// Assumes fault_in is asynchronous; SYNC flops precede edge detection.
module pwm12_fault_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic enable,
    input  logic falling,
    output logic event_o
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;

    // Synchronizer chain built stage by stage
    genvar i;
    generate
        for (i = 0; i < SYNC; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= fault_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC-1];
    end

    // Select the valid edge
    always_comb begin
        if (falling) event_o = enable && prev_q && !sync_q[SYNC-1];
        else         event_o = enable && !prev_q && sync_q[SYNC-1];
    end
endmodule

// File: rtl/pwm12_core.sv
// Counter and compare stage: runs, wraps or halts at the period value, and
// flags the active phase while the count is below duty.
// Assumes stop has priority over start, and start over tick.
module pwm12_core #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             start,
    input  logic             tick,
    input  logic             oneshot,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             active
);
    // Run state and counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (stop) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (tick) begin
            if (cnt == period) begin
                if (oneshot) running <= 1'b0;
                else         cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Active phase of the waveform
    always_comb active = running && (cnt < duty);
endmodule

// File: rtl/pwm12_fault_gen.sv
// Top level: register write port, prescaler, counter/compare, fault latch and
// output polarity. Assumes a single write per cycle and CNT_W >= 7.
module pwm12_fault_gen
    import pwm12_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEL_W = 2,
    parameter int SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              fault_in,
    output logic              pwm_out,
    output logic              fault_irq,
    output logic              gpio_mode,
    output logic [CNT_W-1:0]  ctrl_rd
);
    localparam int PAD_W = CNT_W - 7;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_q;
    logic             flag_q;
    logic             running;
    logic [CNT_W-1:0] cnt;
    logic             active;
    logic             tick;
    logic             fault_ev;
    logic             start_req;
    logic             mode_q;
    logic             wr_ctrl;

    // Decode the write strobes
    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        start_req = wr_ctrl && wr_data[B_START] && !flag_q;
        mode_q    = ctrl_q.oneshot;
    end

    // Control register: accepted only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl && !running) begin
            ctrl_q.oneshot <= wr_data[B_MODE];
            ctrl_q.sel     <= wr_data[B_SEL_LO +: SEL_W];
            ctrl_q.pol     <= wr_data[B_POL];
            ctrl_q.pmode   <= port_mode_e'(wr_data[B_PORT_LO +: 2]);
        end
    end

    // Compare values: writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            duty_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_PERIOD) period_q <= wr_data;
            if (wr_addr == A_DUTY)   duty_q   <= wr_data;
        end
    end

    // Sticky fault flag, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)                                        flag_q <= 1'b0;
        else if (fault_ev)                                 flag_q <= 1'b1;
        else if (wr_en && wr_addr == A_FLAG && !wr_data[0]) flag_q <= 1'b0;
    end

    pwm12_prescaler #(.SEL_W(SEL_W)) u_pres (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fault_ev || start_req),
        .en    (running),
        .sel   (ctrl_q.sel),
        .tick  (tick)
    );

    pwm12_fault_det #(.SYNC(SYNC)) u_fdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_in (fault_in),
        .enable   (ctrl_q.pmode[1]),
        .falling  (ctrl_q.pmode[0]),
        .event_o  (fault_ev)
    );

    pwm12_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop    (fault_ev),
        .start   (start_req),
        .tick    (tick),
        .oneshot (ctrl_q.oneshot),
        .period  (period_q),
        .duty    (duty_q),
        .running (running),
        .cnt     (cnt),
        .active  (active)
    );

    // Pin level, status and readback
    always_comb begin
        gpio_mode = (ctrl_q.pmode == PM_GPIO);
        pwm_out   = (active && !gpio_mode) ^ ctrl_q.pol;
        fault_irq = flag_q;
        ctrl_rd   = {{PAD_W{1'b0}}, ctrl_q.oneshot, ctrl_q.sel, ctrl_q.pol,
                     1'b0, ctrl_q.pmode};
    end
endmodule

// File: rtl/pwm12_fault_gen_chk.sv
// Assertion checker for pwm12_fault_gen, attached by bind below.
module pwm12_fault_gen_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             pwm_out,
    input logic             fault_irq,
    input logic [CNT_W-1:0] ctrl_rd,
    input logic             running,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period_q,
    input logic             tick,
    input logic             start_req,
    input logic             fault_ev,
    input logic             mode_q
);
    // R6: a freshly raised fault leaves the pin at its idle level
    a_r6_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_irq) |-> (pwm_out == ctrl_rd[3]));

    // R7: flag holds unless cleared by a zero write
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq && !(wr_en && wr_addr == 2'd3 && !wr_data[0]) |=> fault_irq);

    // R8: no running timer while the fault flag is set
    a_r8_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |-> !running);

    // R9: configuration frozen while running
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(ctrl_rd));

    // R2: counter moves only on a tick
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        running && !tick && !start_req && !fault_ev |=> $stable(cnt));

    // R5: a start clears the counter and runs
    a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && !fault_ev |=> running && (cnt == '0));

    // R11: one-shot halts at the period value
    a_r11_oneshot_end: assert property (@(posedge clk) disable iff (!rst_n)
        running && mode_q && tick && (cnt == period_q) && !start_req && !fault_ev
        |=> !running);
endmodule

bind pwm12_fault_gen pwm12_fault_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pwm_out   (pwm_out),
    .fault_irq (fault_irq),
    .ctrl_rd   (ctrl_rd),
    .running   (running),
    .cnt       (cnt),
    .period_q  (period_q),
    .tick      (tick),
    .start_req (start_req),
    .fault_ev  (fault_ev),
    .mode_q    (mode_q)
);

// File: tb/pwm12_fault_gen_bench.sv
// Bench with a behavioural reference model compared every cycle.
module pwm12_fault_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [11:0] wr_data = 12'd0;
    logic        fault_in = 1'b0;
    logic        pwm_out, fault_irq, gpio_mode;
    logic [11:0] ctrl_rd;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #5 clk = ~clk;

    pwm12_fault_gen u_pwm12_fault_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fault_in(fault_in), .pwm_out(pwm_out),
        .fault_irq(fault_irq), .gpio_mode(gpio_mode), .ctrl_rd(ctrl_rd)
    );

    // Reference model state
    int m_cnt, m_ps, m_sel, m_run, m_flag, m_pol, m_mode, m_pc, m_per, m_duty;
    int m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        int fe, tk, o_run, trig;
        if (!rst_n) begin
            m_cnt = 0; m_ps = 0; m_sel = 0; m_run = 0; m_flag = 0; m_pol = 0;
            m_mode = 0; m_pc = 0; m_per = 0; m_duty = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            fe = (m_pc >= 2) && ((m_pc == 3) ? (m_s3 == 1 && m_s2 == 0)
                                             : (m_s2 == 1 && m_s3 == 0));
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(fault_in);
            tk = m_run && (m_ps == (1 << m_sel) - 1);
            o_run = m_run;
            trig = wr_en && wr_addr == 2'd0 && wr_data[2] && !m_flag;
            if (fe) begin
                m_flag = 1; m_run = 0; m_cnt = 0; m_ps = 0;
            end else if (trig) begin
                m_run = 1; m_cnt = 0; m_ps = 0;
            end else if (m_run) begin
                if (tk) begin
                    m_ps = 0;
                    if (m_cnt == m_per) begin
                        if (m_mode) m_run = 0; else m_cnt = 0;
                    end else m_cnt = (m_cnt + 1) % 4096;
                end else m_ps = m_ps + 1;
            end
            if (!fe && wr_en && wr_addr == 2'd3 && !wr_data[0]) m_flag = 0;
            if (wr_en && wr_addr == 2'd0 && !o_run) begin
                m_mode = wr_data[6]; m_sel = wr_data[5:4];
                m_pol = wr_data[3]; m_pc = wr_data[1:0];
            end
            if (wr_en && wr_addr == 2'd1) m_per = wr_data;
            if (wr_en && wr_addr == 2'd2) m_duty = wr_data;
        end
    end

    function automatic int model_pin();
        int act;
        act = (m_run && m_pc != 0 && m_cnt < m_duty) ? 1 : 0;
        return act ^ m_pol;
    endfunction

    task automatic cmp(string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    // Per-cycle comparison, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (!finished) begin
            cmp("pwm_out", int'(pwm_out), model_pin());
            cmp("fault_irq", int'(fault_irq), m_flag);
            cmp("gpio_mode", int'(gpio_mode), (m_pc == 0) ? 1 : 0);
            cmp("ctrl_rd", int'(ctrl_rd),
                (m_mode << 6) | (m_sel << 4) | (m_pol << 3) | m_pc);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 12'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; fault_in = 1'b0;
        idle(3); rst_n = 1'b1;
    endtask

    function automatic logic [11:0] cw(int mode, int sel, int pol, int st, int pc);
        return 12'((mode << 6) | (sel << 4) | (pol << 3) | (st << 2) | pc);
    endfunction

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        cmp("reset pwm_out", int'(pwm_out), 0);
        cmp("reset gpio_mode", int'(gpio_mode), 1);
        cmp("reset ctrl_rd", int'(ctrl_rd), 0);

        // R2 / R3: each tick division in repeating mode
        for (int s = 0; s < 4; s++) begin
            cur_req = "R2";
            do_reset();
            wr(2'd1, 12'd5); wr(2'd2, 12'd2);
            wr(2'd0, cw(0, s, 0, 1, 1));
            idle(60);
        end

        // R4: inverted polarity; R12: compare updates while running
        cur_req = "R4";
        do_reset();
        wr(2'd1, 12'd7); wr(2'd2, 12'd3);
        wr(2'd0, cw(0, 0, 1, 1, 1));
        idle(20);
        cur_req = "R12";
        wr(2'd2, 12'd9); idle(20);
        wr(2'd2, 12'd0); idle(20);
        wr(2'd1, 12'd3); wr(2'd2, 12'd2); idle(20);

        // R9: config writes ignored while running; R5: restart, zero start bit
        cur_req = "R9";
        wr(2'd0, cw(1, 3, 0, 0, 2)); idle(10);
        cur_req = "R5";
        wr(2'd0, cw(0, 0, 0, 0, 1)); idle(5);
        wr(2'd0, cw(0, 0, 1, 1, 1)); idle(10);
        cmp("start bit readback", int'(ctrl_rd[2]), 0);

        // R6 / R7 / R8: rising-edge fault, lockout, clear and restart
        cur_req = "R6";
        do_reset();
        wr(2'd1, 12'd9); wr(2'd2, 12'd5);
        wr(2'd0, cw(0, 1, 0, 1, 2));
        idle(13);
        @(negedge clk) fault_in = 1'b1;
        idle(4);
        cmp("fault pin idle", int'(pwm_out), 0);
        cur_req = "R7";
        cmp("fault flag set", int'(fault_irq), 1);
        wr(2'd3, 12'd1); idle(3);
        cur_req = "R8";
        wr(2'd0, cw(0, 1, 0, 1, 2)); idle(5);
        cmp("start locked out", int'(pwm_out), 0);
        cur_req = "R7";
        wr(2'd3, 12'd0); idle(2);
        cmp("flag cleared", int'(fault_irq), 0);
        cur_req = "R8";
        wr(2'd0, cw(0, 1, 0, 1, 2)); idle(40);
        @(negedge clk) fault_in = 1'b0; idle(10);

        // R6: falling-edge mode, and fault ignored in mode 01
        cur_req = "R6";
        do_reset();
        @(negedge clk) fault_in = 1'b1;
        wr(2'd1, 12'd4); wr(2'd2, 12'd2);
        wr(2'd0, cw(0, 0, 1, 1, 3)); idle(10);
        @(negedge clk) fault_in = 1'b0; idle(6);
        cmp("falling fault pin idle", int'(pwm_out), 1);
        wr(2'd3, 12'd0); wr(2'd0, cw(0, 0, 0, 1, 1)); idle(8);
        @(negedge clk) fault_in = 1'b1; idle(4);
        @(negedge clk) fault_in = 1'b0; idle(6);
        cmp("fault ignored in mode 01", int'(fault_irq), 0);

        // R10: general-purpose pin mode
        cur_req = "R10";
        do_reset();
        wr(2'd1, 12'd5); wr(2'd2, 12'd4);
        wr(2'd0, cw(0, 0, 0, 1, 0)); idle(15);
        cmp("gpio pin idle", int'(pwm_out), 0);

        // R11: one-shot halts and waits for a new start
        cur_req = "R11";
        do_reset();
        wr(2'd1, 12'd6); wr(2'd2, 12'd3);
        wr(2'd0, cw(1, 1, 0, 1, 1)); idle(30);
        cmp("one-shot idle", int'(pwm_out), 0);
        wr(2'd0, cw(1, 0, 0, 1, 1)); idle(15);

        idle(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL %s watchdog expired", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule